// File: doc/BRIEF.md
# One-Time-Programmable Fuse Bank Controller

This block holds a small bank of one-time-programmable fuse words behind a program port and a read port. The bank holds a production-mode word, a provisioning word, a multi-word secret key, eight field-programmable spare banks of 32 bits, and a lock word for those spare banks. Each word is addressed by an 8-bit selector code. Programming can only set bits. A request goes through a policy check for temperature, address, production mode and lock. If the request passes, the block runs a programming pulse for a fixed number of cycles and then commits the word. If it fails, the block reports an error code and changes nothing.

Key hiding and production mode are sampled into flops while the warm reset `rst_n` is held low. Their effect only appears after the next reset. A key that has just been burned can therefore still be read back and verified before the part is reset. A separate power-on clear `por_n` models a blank die. Each word can be stored twice, and the read value is the OR of the two copies.

The program port is valid/ready. The requester holds `prg_valid`, `prg_sel`, `prg_data` and `temp_c` steady until `prg_ready` is seen high at a clock edge, and all four are sampled on that edge. `prg_ready` is low for the whole programming pulse, which is the only source of back-pressure. The read port is combinational and always available.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After power-on clear and reset, every selector reads 0, `busy`, `done` and `err` are 0, and `prg_ready` is 1.
- R2: An accepted program of word W with data D leaves W equal to its old value OR D. No bit ever returns to 0.
- R3: An accepted request raises `busy` on the cycle after the handshake and holds it for exactly PULSE_CYC cycles. `prg_ready` is low while `busy` is high. When `busy` falls, `done` pulses for one cycle and the new value is readable from that same cycle.
- R4: A request made while `temp_c` is below 29 or above 101 is refused with code 3. The values 29 and 101 are accepted.
- R5: If bit 0 of the production word (selector 0x00) was 1 at the last reset, requests to manufacturing fuses are refused with code 2. Manufacturing fuses are selector 0x00, selector 0x01 and the key words 0x10–0x13. Spare banks and the lock word stay writable.
- R6: Bit i of the lock word (selector 0x30) refuses spare bank i (selector 0x20+i) with code 1, for i in 0..3. Banks 4..7 (0x24–0x27) ignore the lock word.
- R7: If bit 0 of the provisioning word (selector 0x01) or of the production word was 1 at the last reset, the key words read as all ones. Setting those bits has no effect on reads until a reset.
- R8: An unmapped selector is refused with code 0 and reads as 0.
- R9: A refused request pulses `err` for one cycle after the handshake, with `err_code` valid, and changes no fuse. Checks apply in this order: temperature, then address, then production mode, then lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on clear of the fuse array (blank die) |
| rst_n | input | 1 | Active-low warm reset; hide and production state are sampled while it is low |
| temp_c | input | 8 | Die temperature in °C, unsigned |
| prg_valid | input | 1 | Program request valid |
| prg_ready | output | 1 | Program request can be taken |
| prg_sel | input | 8 | Selector code of the word to program |
| prg_data | input | 32 | Bits to set |
| busy | output | 1 | Programming pulse in progress |
| done | output | 1 | One-cycle pulse at the end of an accepted program |
| err | output | 1 | One-cycle pulse for a refused request |
| err_code | output | 2 | 0 unmapped, 1 locked, 2 production mode, 3 temperature |
| rd_sel | input | 8 | Selector code to read |
| rd_data | output | 32 | Read value, with hiding applied |

## Verification
The hardest situation to reach from the ports is the window in which a hide or production bit is already burned but not yet in force. The stimulus burns the provisioning bit, reads the key back in clear, and only then pulses `rst_n` to see the key masked. The same is done with the production bit, with a key program accepted before the reset and refused after it. The random phase mixes sparse writes to every selector with periodic warm resets. That way the hide and production states change mid-run, and a bench model that tracks the reset-time sampling predicts each outcome.

// File: rtl/otp_fuse_pkg.sv
`timescale 1ns/1ps
package otp_fuse_pkg;
  localparam logic [7:0] SEL_PROD = 8'h00;
  localparam logic [7:0] SEL_PROV = 8'h01;
  localparam logic [7:0] SEL_KEY0 = 8'h10;
  localparam logic [7:0] SEL_RSV0 = 8'h20;
  localparam logic [7:0] SEL_LOCK = 8'h30;

  typedef enum logic [1:0] {
    ERR_UNMAPPED = 2'd0,
    ERR_LOCKED   = 2'd1,
    ERR_PROD     = 2'd2,
    ERR_TEMP     = 2'd3
  } otp_err_e;

  typedef struct packed {
    logic       hit;
    logic       manuf;
    logic       key;
    logic       rsv;
    logic [7:0] idx;
    logic [7:0] bank;
  } otp_dec_t;

  // word layout: 0 production, 1 provisioning, keys, spare banks, lock word
  function automatic otp_dec_t otp_decode(input logic [7:0] sel, input int key_words,
                                          input int rsv_banks);
    otp_dec_t d;
    int s;
    s = int'(sel);
    d = '0;
    if (sel == SEL_PROD) begin
      d.hit = 1'b1; d.manuf = 1'b1; d.idx = 8'd0;
    end else if (sel == SEL_PROV) begin
      d.hit = 1'b1; d.manuf = 1'b1; d.idx = 8'd1;
    end else if (s >= int'(SEL_KEY0) && s < int'(SEL_KEY0) + key_words) begin
      d.hit = 1'b1; d.manuf = 1'b1; d.key = 1'b1;
      d.idx = 8'(2 + s - int'(SEL_KEY0));
    end else if (s >= int'(SEL_RSV0) && s < int'(SEL_RSV0) + rsv_banks) begin
      d.hit = 1'b1; d.rsv = 1'b1;
      d.bank = 8'(s - int'(SEL_RSV0));
      d.idx = 8'(2 + key_words + s - int'(SEL_RSV0));
    end else if (sel == SEL_LOCK) begin
      d.hit = 1'b1;
      d.idx = 8'(2 + key_words + rsv_banks);
    end
    return d;
  endfunction

  function automatic logic sel_hit(input logic [7:0] sel, input int k, input int r);
    otp_dec_t d = otp_decode(sel, k, r);
    return d.hit;
  endfunction
  function automatic logic sel_manuf(input logic [7:0] sel, input int k, input int r);
    otp_dec_t d = otp_decode(sel, k, r);
    return d.manuf;
  endfunction
  function automatic logic sel_key(input logic [7:0] sel, input int k, input int r);
    otp_dec_t d = otp_decode(sel, k, r);
    return d.key;
  endfunction
  function automatic logic sel_rsv(input logic [7:0] sel, input int k, input int r);
    otp_dec_t d = otp_decode(sel, k, r);
    return d.rsv;
  endfunction
  function automatic logic [7:0] sel_idx(input logic [7:0] sel, input int k, input int r);
    otp_dec_t d = otp_decode(sel, k, r);
    return d.idx;
  endfunction
  function automatic logic [7:0] sel_bank(input logic [7:0] sel, input int k, input int r);
    otp_dec_t d = otp_decode(sel, k, r);
    return d.bank;
  endfunction
endpackage

// File: rtl/otp_fuse_store.sv
`timescale 1ns/1ps
module otp_fuse_store #(
  parameter int NW        = 15,
  parameter bit REDUNDANT = 1'b1,
  localparam int IW       = $clog2(NW)
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [31:0]           wr_data,
  output logic [NW-1:0][31:0]   words
);
  logic [NW-1:0][31:0] copy_a;

  always_ff @(posedge clk) begin
    if (!por_n) copy_a <= '0;
    else if (wr_en) copy_a[wr_idx] <= copy_a[wr_idx] | wr_data;
  end

  generate
    if (REDUNDANT) begin : g_dual
      logic [NW-1:0][31:0] copy_b;
      always_ff @(posedge clk) begin
        if (!por_n) copy_b <= '0;
        else if (wr_en) copy_b[wr_idx] <= copy_b[wr_idx] | wr_data;
      end
      // a decayed bit in one copy is restored by the other
      assign words = copy_a | copy_b;
    end else begin : g_single
      assign words = copy_a;
    end
  endgenerate
endmodule

// File: rtl/otp_access_policy.sv
`timescale 1ns/1ps
module otp_access_policy
  import otp_fuse_pkg::*;
#(
  parameter int LOCK_BANKS = 4,
  parameter int TEMP_MIN   = 29,
  parameter int TEMP_MAX   = 101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            temp_c,
  input  logic                  req_hit,
  input  logic                  req_manuf,
  input  logic                  req_rsv,
  input  logic [7:0]            req_bank,
  input  logic [LOCK_BANKS-1:0] lock_bits,
  input  logic                  prod_bit,
  input  logic                  prov_bit,
  output logic                  refuse,
  output otp_err_e              code,
  output logic                  hide_q
);
  logic prod_q;
  logic temp_ok;
  logic lock_hit;

  // state taken from the fuses only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= prod_bit;
      hide_q <= prod_bit | prov_bit;
    end
  end

  always_comb begin
    temp_ok  = (temp_c >= 8'(TEMP_MIN)) && (temp_c <= 8'(TEMP_MAX));
    lock_hit = 1'b0;
    for (int b = 0; b < LOCK_BANKS; b++) begin
      if (req_rsv && req_bank == 8'(b) && lock_bits[b]) lock_hit = 1'b1;
    end
    refuse = 1'b1;
    code   = ERR_UNMAPPED;
    if (!temp_ok)                code = ERR_TEMP;
    else if (!req_hit)           code = ERR_UNMAPPED;
    else if (req_manuf && prod_q) code = ERR_PROD;
    else if (lock_hit)           code = ERR_LOCKED;
    else                         refuse = 1'b0;
  end
endmodule

// File: rtl/otp_prog_seq.sv
`timescale 1ns/1ps
module otp_prog_seq
  import otp_fuse_pkg::*;
#(
  parameter int PULSE_CYC = 6,
  parameter int IW        = 4,
  localparam int CW       = $clog2(PULSE_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prg_valid,
  output logic          prg_ready,
  input  logic [IW-1:0] req_idx,
  input  logic [31:0]   prg_data,
  input  logic          refuse,
  input  otp_err_e      code,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_code,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [31:0]   wr_data
);
  logic [CW-1:0] cnt;

  assign prg_ready = !busy;
  assign wr_en     = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= 2'd0;
      cnt      <= '0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (prg_valid) begin
        if (refuse) begin
          err      <= 1'b1;
          err_code <= code;
        end else begin
          busy    <= 1'b1;
          cnt     <= CW'(PULSE_CYC - 1);
          wr_idx  <= req_idx;
          wr_data <= prg_data;
        end
      end
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
`timescale 1ns/1ps
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int KEY_WORDS  = 4,
  parameter int RSV_BANKS  = 8,
  parameter int LOCK_BANKS = 4,
  parameter int PULSE_CYC  = 6,
  parameter int TEMP_MIN   = 29,
  parameter int TEMP_MAX   = 101,
  parameter bit REDUNDANT  = 1'b1,
  localparam int NW        = 3 + KEY_WORDS + RSV_BANKS,
  localparam int IW        = $clog2(NW)
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic [7:0]  temp_c,
  input  logic        prg_valid,
  output logic        prg_ready,
  input  logic [7:0]  prg_sel,
  input  logic [31:0] prg_data,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [1:0]  err_code,
  input  logic [7:0]  rd_sel,
  output logic [31:0] rd_data
);
  logic [NW-1:0][31:0] fuse_words;
  logic                refuse;
  otp_err_e            code;
  logic                hide_q;
  logic                wr_en;
  logic [IW-1:0]       wr_idx;
  logic [31:0]         wr_data;

  otp_fuse_store #(.NW(NW), .REDUNDANT(REDUNDANT)) store_i (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .words(fuse_words)
  );

  otp_access_policy #(.LOCK_BANKS(LOCK_BANKS), .TEMP_MIN(TEMP_MIN), .TEMP_MAX(TEMP_MAX)) policy_i (
    .clk(clk), .rst_n(rst_n), .temp_c(temp_c),
    .req_hit(sel_hit(prg_sel, KEY_WORDS, RSV_BANKS)),
    .req_manuf(sel_manuf(prg_sel, KEY_WORDS, RSV_BANKS)),
    .req_rsv(sel_rsv(prg_sel, KEY_WORDS, RSV_BANKS)),
    .req_bank(sel_bank(prg_sel, KEY_WORDS, RSV_BANKS)),
    .lock_bits(fuse_words[NW-1][LOCK_BANKS-1:0]),
    .prod_bit(fuse_words[0][0]), .prov_bit(fuse_words[1][0]),
    .refuse(refuse), .code(code), .hide_q(hide_q)
  );

  otp_prog_seq #(.PULSE_CYC(PULSE_CYC), .IW(IW)) seq_i (
    .clk(clk), .rst_n(rst_n), .prg_valid(prg_valid), .prg_ready(prg_ready),
    .req_idx(IW'(sel_idx(prg_sel, KEY_WORDS, RSV_BANKS))), .prg_data(prg_data),
    .refuse(refuse), .code(code), .busy(busy), .done(done), .err(err),
    .err_code(err_code), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  always_comb begin
    rd_data = '0;
    if (sel_hit(rd_sel, KEY_WORDS, RSV_BANKS)) begin
      if (sel_key(rd_sel, KEY_WORDS, RSV_BANKS) && hide_q) rd_data = '1;
      else rd_data = fuse_words[IW'(sel_idx(rd_sel, KEY_WORDS, RSV_BANKS))];
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_chk
  import otp_fuse_pkg::*;
#(
  parameter int NW        = 15,
  parameter int KEY_WORDS = 4,
  parameter int TEMP_MIN  = 29,
  parameter int TEMP_MAX  = 101
) (
  input logic                clk,
  input logic                por_n,
  input logic                rst_n,
  input logic [7:0]          temp_c,
  input logic                prg_valid,
  input logic                prg_ready,
  input logic                busy,
  input logic                done,
  input logic                err,
  input logic [1:0]          err_code,
  input logic [7:0]          rd_sel,
  input logic [31:0]         rd_data,
  input logic                hide_q,
  input logic [NW-1:0][31:0] words
);
  // R2
  one_way_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (($past(words) & ~words) == '0));

  // R3
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prg_ready);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R9
  err_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(prg_valid && prg_ready));

  // R9
  err_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && done));

  // R4
  temp_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_valid && prg_ready && (temp_c < 8'(TEMP_MIN) || temp_c > 8'(TEMP_MAX)))
      |=> (err && err_code == 2'd3));

  // R7
  key_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hide_q && rd_sel >= SEL_KEY0 && int'(rd_sel) < int'(SEL_KEY0) + KEY_WORDS)
      |-> (rd_data == '1));
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
  .NW(NW), .KEY_WORDS(KEY_WORDS), .TEMP_MIN(TEMP_MIN), .TEMP_MAX(TEMP_MAX)
) chk_i (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .temp_c(temp_c),
  .prg_valid(prg_valid), .prg_ready(prg_ready), .busy(busy), .done(done),
  .err(err), .err_code(err_code), .rd_sel(rd_sel), .rd_data(rd_data),
  .hide_q(hide_q), .words(fuse_words)
);

// File: tb/otp_fuse_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb_top;
  localparam int K = 4, R = 8, L = 4, P = 6, NW = 3 + K + R;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic [7:0] temp_c = 8'd50;
  logic prg_valid = 1'b0;
  logic [7:0] prg_sel = '0;
  logic [31:0] prg_data = '0;
  logic [7:0] rd_sel = '0;
  logic prg_ready, busy, done, err;
  logic [1:0] err_code;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  logic [31:0] m [NW];
  bit m_hide = 1'b0, m_prod = 1'b0;

  always #2.5 clk = ~clk;

  otp_fuse_ctrl #(.KEY_WORDS(K), .RSV_BANKS(R), .LOCK_BANKS(L), .PULSE_CYC(P)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .temp_c(temp_c), .prg_valid(prg_valid),
    .prg_ready(prg_ready), .prg_sel(prg_sel), .prg_data(prg_data), .busy(busy),
    .done(done), .err(err), .err_code(err_code), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic int midx(input logic [7:0] s);
    if (s == 8'h00) return 0;
    if (s == 8'h01) return 1;
    if (s >= 8'h10 && s < 8'h10 + K) return 2 + int'(s) - 16;
    if (s >= 8'h20 && s < 8'h20 + R) return 2 + K + int'(s) - 32;
    if (s == 8'h30) return NW - 1;
    return -1;
  endfunction

  function automatic bit is_key(input logic [7:0] s);
    return s >= 8'h10 && s < 8'h10 + K;
  endfunction

  function automatic int exp_code(input logic [7:0] s, input logic [7:0] t);
    int i = midx(s);
    if (t < 8'd29 || t > 8'd101) return 3;
    if (i < 0) return 0;
    if (i < 2 + K && m_prod) return 2;
    if (s >= 8'h20 && s < 8'h20 + L && m[NW-1][int'(s) - 32]) return 1;
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] s);
    int i = midx(s);
    if (i < 0) return 32'h0;
    if (is_key(s) && m_hide) return 32'hFFFF_FFFF;
    return m[i];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [7:0] s, input string req);
    rd_sel = s;
    #0.5;
    chk(rd_data === exp_read(s), req, rd_data, exp_read(s));
  endtask

  task automatic do_reset(input bit power);
    @(negedge clk);
    rst_n = 1'b0;
    if (power) por_n = 1'b0;
    repeat (3) @(negedge clk);
    if (power) foreach (m[i]) m[i] = '0;
    m_hide = m[1][0] | m[0][0];
    m_prod = m[0][0];
    por_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog(input logic [7:0] s, input logic [31:0] d, input logic [7:0] t, input string req);
    int ec, n;
    ec = exp_code(s, t);
    @(negedge clk);
    prg_valid = 1'b1; prg_sel = s; prg_data = d; temp_c = t;
    @(negedge clk);
    prg_valid = 1'b0;
    if (ec >= 0) begin
      chk(err === 1'b1 && int'(err_code) == ec && busy === 1'b0, req,
          {29'd0, err, err_code}, {29'd0, 1'b1, 2'(ec)});
    end else begin
      chk(busy === 1'b1 && prg_ready === 1'b0 && err === 1'b0, req, {30'd0, busy, prg_ready}, 32'h2);
      n = 0;
      while (busy === 1'b1 && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk(n == P && done === 1'b1, {req, " pulse"}, 32'(n), 32'(P));
      m[midx(s)] = m[midx(s)] | d;
    end
    read_chk(s, req);
  endtask

  function automatic logic [7:0] pick_sel(input int r);
    if (r == 0) return 8'h00;
    if (r == 1) return 8'h01;
    if (r < 6) return 8'(16 + r - 2);
    if (r < 14) return 8'(32 + r - 6);
    if (r == 14) return 8'h30;
    return 8'h05;
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0F0F));
    foreach (m[i]) m[i] = '0;
    do_reset(1'b1);
    // R1 blank state
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && prg_ready === 1'b1, "R1",
        {28'd0, busy, done, err, prg_ready}, 32'h1);
    read_chk(8'h10, "R1"); read_chk(8'h20, "R1"); read_chk(8'h30, "R1"); read_chk(8'h00, "R1");
    // R2 one-way accumulation
    prog(8'h10, 32'h0000_00F0, 8'd50, "R2");
    prog(8'h10, 32'h0F00_000F, 8'd50, "R2");
    prog(8'h10, 32'h0000_0000, 8'd50, "R2");
    chk(exp_read(8'h10) == 32'h0F00_00FF, "R2 model", exp_read(8'h10), 32'h0F00_00FF);
    // R4 temperature window edges
    prog(8'h20, 32'h1, 8'd28, "R4");
    prog(8'h20, 32'h1, 8'd102, "R4");
    prog(8'h20, 32'h1, 8'd29, "R4");
    prog(8'h20, 32'h2, 8'd101, "R4");
    // R8 unmapped, and R9 priority of temperature over address
    prog(8'h07, 32'hFFFF_FFFF, 8'd50, "R8");
    read_chk(8'h07, "R8");
    prog(8'h07, 32'hFFFF_FFFF, 8'd10, "R9");
    // R6 lock bits, upper banks unaffected
    prog(8'h30, 32'h0000_00F2, 8'd50, "R6");
    prog(8'h21, 32'h55, 8'd50, "R6");
    prog(8'h25, 32'h55, 8'd50, "R6");
    prog(8'h20, 32'h80, 8'd50, "R6");
    // R7 hide deferred to next reset
    prog(8'h01, 32'h1, 8'd50, "R7");
    read_chk(8'h10, "R7");
    chk(rd_data == 32'h0F00_00FF, "R7 clear", rd_data, 32'h0F00_00FF);
    do_reset(1'b0);
    read_chk(8'h10, "R7");
    chk(rd_data == 32'hFFFF_FFFF, "R7 hidden", rd_data, 32'hFFFF_FFFF);
    prog(8'h11, 32'hA5, 8'd50, "R7");
    // R5 production mode, effective after reset
    prog(8'h00, 32'h1, 8'd50, "R5");
    prog(8'h12, 32'h3, 8'd50, "R5");
    do_reset(1'b0);
    prog(8'h12, 32'h4, 8'd50, "R5");
    prog(8'h01, 32'h2, 8'd50, "R5");
    prog(8'h22, 32'h9, 8'd50, "R5");
    prog(8'h30, 32'h100, 8'd50, "R5");
    prog(8'h13, 32'h1, 8'd10, "R9");
    prog(8'h23, 32'h7, 8'd50, "R6");
    // random phase over a fresh die
    do_reset(1'b1);
    for (int n = 0; n < 240; n++) begin
      logic [7:0] s;
      logic [31:0] d;
      s = pick_sel(int'($urandom % 16));
      d = $urandom & $urandom;
      if (s <= 8'h01) d = d & $urandom & $urandom;
      prog(s, d, 8'(20 + ($urandom % 90)), "R9 random");
      if (n % 40 == 39) do_reset(1'b0);
    end
    for (int r = 0; r < 16; r++) read_chk(pick_sel(r), "R2 scan");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule